// File: doc/BRIEF.md
# Counter-Reseeded Pseudo-Random Pattern Generator

This block feeds pseudo-random stimulus to a circuit under test without any stored seeds. A seed counter steps through every non-zero value of an n-bit word. Each counter value is loaded into a maximal-length external-XOR shift register. The register then runs for exactly one full period from that value before the next seed replaces it. Every seed walks the same cyclic sequence, but each one enters that sequence at a different point. The pattern stream is therefore exhaustive per seed, and the only storage it needs is a counter.

A single-cycle `start` pulse begins a run at seed 1. The active-low `run_n` input freezes the generator whenever it is high. `pat_vld` marks every cycle that presents a fresh pattern. `seed` shows which seed the current pattern came from. `done` rises once the last seed has used up its period, and generation then stops until the next start.

Top module: `reseed_lfsr_tpg`

## Requirements
- R1: While `rst_n` is low, `pattern`, `seed`, `pat_vld` and `done` are all 0.
- R2: A clock edge with `start` = 1 sets `seed` to 1, clears `done` and drives `pat_vld` to 0, whatever the level of `run_n`. At the next edge where `run_n` = 0, `pattern` becomes the seed value 1 and `pat_vld` becomes 1.
- R3: On each advancing edge inside a seed's period, the next pattern is `{p[W-2:0], ^(p & TAPS)}`. With the default W=4 and TAPS=4'b1100 (x^4+x^3+1), starting from 0001 the patterns are 1,2,4,9,3,6,D,A,5,B,7,F,E,C,8 (hex).
- R4: Each seed presents exactly 2^W-1 consecutive patterns (its load plus 2^W-2 shifts). `seed` stays constant for all of them.
- R5: On the edge after the last pattern of seed s (s < 2^W-1), `seed` and `pattern` both become s+1 and `pat_vld` stays 1. No idle cycle is inserted between seeds.
- R6: `pattern` is never 0 while `pat_vld` is 1.
- R7: On the edge after seed 2^W-1 has shown its last pattern, `done` becomes 1 and `pat_vld` becomes 0. `pattern`, `seed` and `done` then hold until the next start.
- R8: While `run_n` = 1, `pattern`, `seed` and `done` do not change and `pat_vld` is 0. After `run_n` returns to 0, the sequence resumes from the held pattern.
- R9: `pat_vld` is 1 on every cycle that presents a new pattern, including the cycle that shows a freshly loaded seed.
- R10: The width W (2 to 32) and the feedback mask TAPS are parameters. A W=3 instance with TAPS=3'b110 gives 7 patterns per seed and 49 valid cycles per run before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_n | input | 1 | 0 = advance every clock, 1 = hold all state |
| start | input | 1 | One-cycle pulse that restarts the run at seed 1 |
| pattern | output | W | Current test pattern |
| pat_vld | output | 1 | High on cycles that present a new pattern |
| seed | output | W | Seed that produced the current pattern |
| done | output | 1 | High once the final seed has finished its period |

## Verification
Every output is registered, so each one responds on the edge after the input that causes it. After a start edge, `seed` reads 1 at once. The first pattern appears one edge later. Each later pattern, reseed and the `done` flag move exactly one edge after the previous one. The bench drives inputs on the falling edge and reads outputs on the next falling edge. Its model therefore steps forward once per rising edge in between, and the model is never read in the same cycle it is updated. Hold windows are checked on the falling edges after each held rising edge, and the check on resume expects the next pattern after the held one.

// File: rtl/reseed_lfsr_tpg.sv
module reseed_lfsr_tpg #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_n,
  input  logic         start,
  output logic [W-1:0] pattern,
  output logic         pat_vld,
  output logic [W-1:0] seed,
  output logic         done
);
  localparam logic [W-1:0] LAST = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] lfsr, cnt;
  logic         busy, loadp;

  wire [W-1:0] lfsr_nx = {lfsr[W-2:0], ^(lfsr & TAPS)};
  wire         adv     = busy && !run_n;
  wire         wrap    = cnt == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr    <= '0;
      seed    <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      loadp   <= 1'b0;
      pat_vld <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      seed    <= ONE;
      cnt     <= '0;
      busy    <= 1'b1;
      loadp   <= 1'b1;
      pat_vld <= 1'b0;
      done    <= 1'b0;
    end else if (!adv) begin
      pat_vld <= 1'b0;
    end else if (loadp) begin
      lfsr    <= seed;
      cnt     <= ONE;
      loadp   <= 1'b0;
      pat_vld <= 1'b1;
    end else if (wrap) begin
      if (seed == LAST) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        pat_vld <= 1'b0;
      end else begin
        seed    <= seed + ONE;
        lfsr    <= seed + ONE;
        cnt     <= ONE;
        pat_vld <= 1'b1;
      end
    end else begin
      lfsr    <= lfsr_nx;
      cnt     <= cnt + ONE;
      pat_vld <= 1'b1;
    end
  end

  assign pattern = lfsr;

  AST_NO_ZERO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |-> pattern != '0);  // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !start) |=> ($stable(pattern) && $stable(seed) && $stable(done) && !pat_vld));  // R8

  AST_SEED_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (seed == $past(seed) || seed == $past(seed) + ONE));  // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (seed == ONE && !done && !pat_vld));  // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pat_vld);  // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pattern) && $stable(seed)));  // R7
endmodule

// File: tb/sim_reseed_lfsr_tpg.sv
module sim_reseed_lfsr_tpg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] pattern, seed;
  logic       pat_vld, done;
  logic [2:0] pattern3, seed3;
  logic       pat_vld3, done3;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  reseed_lfsr_tpg #(.W(4), .TAPS(4'b1100)) u0 (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .start(start),
    .pattern(pattern), .pat_vld(pat_vld), .seed(seed), .done(done));

  reseed_lfsr_tpg #(.W(3), .TAPS(3'b110)) u1 (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .start(start),
    .pattern(pattern3), .pat_vld(pat_vld3), .seed(seed3), .done(done3));

  localparam logic [3:0] SEQ1 [15] = '{4'h1, 4'h2, 4'h4, 4'h9, 4'h3, 4'h6, 4'hD,
                                       4'hA, 4'h5, 4'hB, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8};

  function automatic logic [3:0] step4(input logic [3:0] p);
    return {p[2:0], p[3] ^ p[2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp;
    int vcnt;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 pattern", pattern, 0);
    chk("R1 seed", seed, 0);
    chk("R1 pat_vld", pat_vld, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;

    // R2 start
    pulse_start();
    chk("R2 seed", seed, 1);
    chk("R2 pat_vld", pat_vld, 0);
    chk("R2 done", done, 0);
    @(negedge clk);
    chk("R2 load pattern", pattern, 1);
    chk("R9 load valid", pat_vld, 1);

    // R3 vector table for seed 1
    for (int j = 0; j < 15; j++) begin
      chk("R3 pattern", pattern, SEQ1[j]);
      chk("R4 seed stable", seed, 1);
      @(negedge clk);
    end

    // R4 R5 R6 R9 remaining seeds
    for (int s = 2; s < 16; s++) begin
      exp = 4'(s);
      for (int j = 0; j < 15; j++) begin
        if (j == 0) chk("R5 reseed pattern", pattern, exp);
        else        chk("R3 pattern", pattern, exp);
        chk("R4 seed", seed, s);
        chk("R9 valid", pat_vld, 1);
        chk("R6 nonzero", pattern == 0, 0);
        exp = step4(exp);
        @(negedge clk);
      end
    end

    // R7 done after last seed
    chk("R7 done", done, 1);
    chk("R7 valid low", pat_vld, 0);
    chk("R7 pattern held", pattern, 4'h7);
    chk("R7 seed held", seed, 15);
    repeat (3) @(negedge clk);
    chk("R7 done sticky", done, 1);
    chk("R7 pattern sticky", pattern, 4'h7);

    // R8 hold
    pulse_start();
    chk("R2 restart done clear", done, 0);
    @(negedge clk);
    chk("R8 pre pattern", pattern, 1);
    @(negedge clk);
    chk("R8 pre pattern2", pattern, 2);
    run_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8 held pattern", pattern, 2);
      chk("R8 held valid", pat_vld, 0);
      chk("R8 held seed", seed, 1);
    end
    run_n = 1'b0;
    @(negedge clk);
    chk("R8 resume pattern", pattern, 4);
    chk("R8 resume valid", pat_vld, 1);

    // R2 start while held, mid-run
    run_n = 1'b1;
    pulse_start();
    chk("R2 start in hold seed", seed, 1);
    chk("R2 start in hold valid", pat_vld, 0);
    @(negedge clk);
    chk("R2 no load while held", pat_vld, 0);
    run_n = 1'b0;
    @(negedge clk);
    chk("R2 load after hold", pattern, 1);

    // R10 width 3 instance
    pulse_start();
    vcnt = 0;
    for (int k = 0; k < 80 && !done3; k++) begin
      @(negedge clk);
      if (pat_vld3) vcnt++;
    end
    chk("R10 valid cycles", vcnt, 49);
    chk("R10 done", done3, 1);
    chk("R10 last seed", seed3, 7);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule